// File: doc/BRIEF.md
# 64-bit Integer ALU with Bit-Manipulation and Branch Compare

This block is the integer execution datapath of a 64-bit processor pipeline. Each cycle it can accept one operation, selected by an 8-bit operation code, on two 64-bit operands. It returns a 64-bit result and a branch-taken flag one clock later, along with an output valid.

The operation code is a structured field, and decode works on bit slices of it. Bit 7 marks a 32-bit word operation. Bits 6:5 pick the group: miscellaneous/branch, add, shift or subtract. The low bits pick the function within the group. The supported functions are:

- plain and inverted-operand logic
- sign/zero extension and byte operations
- shifted address adds
- shifts, rotates and single-bit operations
- comparisons and min/max
- 32-bit word variants of several of these

Branch conditions are also evaluated here: a two-bit compare kind, with the low code bit inverting the outcome. Target address computation, redirects, multiplication, division, carry-less products and bit counting belong to other units.

Top module: `int_alu64`

## Requirements
- R1: While reset is asserted and after its release before any valid input, out_vld, out_res and out_taken are all zero.
- R2: out_vld is high exactly in the cycle after a cycle with in_vld high. Back-to-back inputs give back-to-back results. When in_vld is low, out_res and out_taken keep their previous values.
- R3: Logic codes: 0x00 AND, 0x01 AND with inverted b, 0x02 OR, 0x03 OR with inverted b, 0x04 XOR, 0x05 XNOR.
- R4: Extension/byte codes: 0x08 sign-extends a[7:0], 0x09 sign-extends a[15:0], 0x0A zero-extends a[15:0]. 0x0C sets each byte to 0xFF if it is non-zero and to 0x00 otherwise. 0x0D reverses the byte order of a.
- R5: Add codes 0x20–0x27 give (s << op[2:1]) + b. Here s is a when op[0] is 1, and a zero-extended from a[31:0] when op[0] is 0.
- R6: 64-bit shift codes use b[5:0] as the amount: 0x40 shifts zero-extended a[31:0] left, 0x41 shift left, 0x49 logical right, 0x4C arithmetic right, 0x50 rotate left, 0x58 rotate right.
- R7: Single-bit codes use b[5:0] as the bit index: 0x44 clears the bit, 0x45 sets it, 0x46 flips it, and 0x4A returns that bit of a in result bit 0.
- R8: Compare codes: 0x60 a−b, 0x61 unsigned a<b (as 0/1), 0x62 signed a<b, 0x64 unsigned max, 0x65 unsigned min, 0x66 signed max, 0x67 signed min.
- R9: Branch codes 0x10, 0x11, 0x14, 0x15, 0x16, 0x17. op[2:1] picks the compare: 00 equal, 10 signed less-than, 11 unsigned less-than. op[0] inverts the outcome. out_taken gives the outcome and out_res is zero.
- R10: Word codes 0xA1 add, 0xE0 subtract, 0xC0 shift left, 0xC9 logical right, 0xCC arithmetic right, 0xD0 rotate left, 0xD8 rotate right. They work on a[31:0] with amount b[4:0], and the 32-bit result is sign-extended from bit 31.
- R11: out_taken is zero for every non-branch code. Any code not listed above gives a zero out_res and a zero out_taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operation strobe |
| in_op | input | 8 | Structured operation code |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand or shift amount / bit index |
| out_vld | output | 1 | Result valid, one cycle after in_vld |
| out_res | output | 64 | Registered result |
| out_taken | output | 1 | Registered branch outcome |

## Verification
The logic operands mix set, clear and partial nibbles in every 16-bit lane, so that the inverted-operand forms cannot be confused with their plain twins. A negative/positive operand pair separates the signed from the unsigned compare, min/max and branch kinds, and an equal pair covers the equality and greater-or-equal edges. Shift amounts and bit indices carry set bits above the used field, which distinguishes the 6-bit from the 5-bit masking. Word operands carry unrelated upper halves and land on bit 31, showing that only the low half is used and that the result is sign-extended. Unlisted codes are applied after a non-zero result, so that a zero output cannot be stale.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int XLEN  = 64;
  localparam int WLEN  = XLEN / 2;
  localparam int NBYTE = XLEN / 8;
  localparam int OPW   = 8;
  localparam int AMTW  = $clog2(XLEN);
  localparam int AMTWW = $clog2(WLEN);

  typedef logic [OPW-1:0]  op_t;
  typedef logic [XLEN-1:0] word_t;

  function automatic word_t f_zext_lo(input word_t x);
    return {{WLEN{1'b0}}, x[WLEN-1:0]};
  endfunction

  function automatic word_t f_sext_lo(input word_t x);
    return {{WLEN{x[WLEN-1]}}, x[WLEN-1:0]};
  endfunction

  function automatic word_t f_rotl(input word_t x, input logic [AMTW-1:0] n);
    logic [2*XLEN-1:0] d;
    d = {x, x} << n;
    return d[2*XLEN-1:XLEN];
  endfunction

  function automatic word_t f_rotr(input word_t x, input logic [AMTW-1:0] n);
    logic [2*XLEN-1:0] d;
    d = {x, x} >> n;
    return d[XLEN-1:0];
  endfunction

  function automatic logic [WLEN-1:0] f_rotl_w(input logic [WLEN-1:0] x, input logic [AMTWW-1:0] n);
    logic [2*WLEN-1:0] d;
    d = {x, x} << n;
    return d[2*WLEN-1:WLEN];
  endfunction

  function automatic logic [WLEN-1:0] f_rotr_w(input logic [WLEN-1:0] x, input logic [AMTWW-1:0] n);
    logic [2*WLEN-1:0] d;
    d = {x, x} >> n;
    return d[WLEN-1:0];
  endfunction

  function automatic logic f_legal(input op_t op);
    case (op)
      8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05,
      8'h08, 8'h09, 8'h0A, 8'h0C, 8'h0D,
      8'h10, 8'h11, 8'h14, 8'h15, 8'h16, 8'h17,
      8'h20, 8'h21, 8'h22, 8'h23, 8'h24, 8'h25, 8'h26, 8'h27,
      8'h40, 8'h41, 8'h44, 8'h45, 8'h46, 8'h49, 8'h4A, 8'h4C, 8'h50, 8'h58,
      8'h60, 8'h61, 8'h62, 8'h64, 8'h65, 8'h66, 8'h67,
      8'hA1, 8'hE0, 8'hC0, 8'hC9, 8'hCC, 8'hD0, 8'hD8: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import alu_pkg::*;
(
  input  logic [3:0] sel,
  input  word_t      src_a,
  input  word_t      src_b,
  output word_t      res
);
  word_t opnd_b, lg_res, ext_res, orc_v, rev_v;

  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    assign orc_v[8*i +: 8] = {8{|src_a[8*i +: 8]}};
    assign rev_v[8*i +: 8] = src_a[8*(NBYTE-1-i) +: 8];
  end

  assign opnd_b = sel[0] ? ~src_b : src_b;

  always_comb begin
    case (sel[2:1])
      2'b00:   lg_res = src_a & opnd_b;
      2'b01:   lg_res = src_a | opnd_b;
      2'b10:   lg_res = src_a ^ opnd_b;
      default: lg_res = '0;
    endcase
    case (sel[2:0])
      3'b000:  ext_res = {{(XLEN-8){src_a[7]}}, src_a[7:0]};
      3'b001:  ext_res = {{(XLEN-16){src_a[15]}}, src_a[15:0]};
      3'b010:  ext_res = {{(XLEN-16){1'b0}}, src_a[15:0]};
      3'b100:  ext_res = orc_v;
      3'b101:  ext_res = rev_v;
      default: ext_res = '0;
    endcase
  end

  assign res = sel[3] ? ext_res : lg_res;
endmodule

// File: rtl/alu_adder.sv
module alu_adder
  import alu_pkg::*;
(
  input  logic [2:0] sel,
  input  word_t      src_a,
  input  word_t      src_b,
  output word_t      res
);
  word_t base;
  assign base = sel[0] ? src_a : f_zext_lo(src_a);
  assign res  = (base << sel[2:1]) + src_b;
endmodule

// File: rtl/alu_compare.sv
module alu_compare
  import alu_pkg::*;
(
  input  logic [2:0] sel,
  input  word_t      src_a,
  input  word_t      src_b,
  output word_t      res,
  output logic       cond
);
  logic lt_s, lt_u, eq;
  assign lt_s = $signed(src_a) < $signed(src_b);
  assign lt_u = src_a < src_b;
  assign eq   = src_a == src_b;

  always_comb begin
    case (sel)
      3'b000:  res = src_a - src_b;
      3'b001:  res = {{(XLEN-1){1'b0}}, lt_u};
      3'b010:  res = {{(XLEN-1){1'b0}}, lt_s};
      3'b100:  res = lt_u ? src_b : src_a;
      3'b101:  res = lt_u ? src_a : src_b;
      3'b110:  res = lt_s ? src_b : src_a;
      3'b111:  res = lt_s ? src_a : src_b;
      default: res = '0;
    endcase
    case (sel[2:1])
      2'b00:   cond = eq;
      2'b10:   cond = lt_s;
      2'b11:   cond = lt_u;
      default: cond = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
  import alu_pkg::*;
(
  input  logic [5:0]      sel,
  input  word_t           src,
  input  logic [AMTW-1:0] amt,
  output word_t           res
);
  logic [WLEN-1:0]  lo;
  logic [AMTWW-1:0] amt_w;
  word_t            bit_mask;

  assign lo       = src[WLEN-1:0];
  assign amt_w    = amt[AMTWW-1:0];
  assign bit_mask = word_t'(1) << amt;

  always_comb begin
    case (sel)
      6'b0_00000: res = f_zext_lo(src) << amt;
      6'b0_00001: res = src << amt;
      6'b0_00100: res = src & ~bit_mask;
      6'b0_00101: res = src | bit_mask;
      6'b0_00110: res = src ^ bit_mask;
      6'b0_01001: res = src >> amt;
      6'b0_01010: res = {{(XLEN-1){1'b0}}, src[amt]};
      6'b0_01100: res = word_t'($signed(src) >>> amt);
      6'b0_10000: res = f_rotl(src, amt);
      6'b0_11000: res = f_rotr(src, amt);
      6'b1_00000: res = {{WLEN{1'b0}}, lo << amt_w};
      6'b1_01001: res = {{WLEN{1'b0}}, lo >> amt_w};
      6'b1_01100: res = {{WLEN{1'b0}}, $signed(lo) >>> amt_w};
      6'b1_10000: res = {{WLEN{1'b0}}, f_rotl_w(lo, amt_w)};
      6'b1_11000: res = {{WLEN{1'b0}}, f_rotr_w(lo, amt_w)};
      default:    res = '0;
    endcase
  end
endmodule

// File: rtl/int_alu64.sv
module int_alu64
  import alu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_vld,
  input  logic [OPW-1:0]  in_op,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic            out_vld,
  output logic [XLEN-1:0] out_res,
  output logic            out_taken
);
  logic  op_legal, is_branch, is_word, br_cond, taken_nxt;
  word_t bw_res, add_res, cmp_res, sh_res, raw_res, res_nxt;

  assign op_legal  = f_legal(in_op);
  assign is_word   = in_op[7];
  assign is_branch = op_legal && (in_op[6:3] == 4'b0010);

  alu_bitwise u_bitwise (.sel(in_op[3:0]), .src_a(in_a), .src_b(in_b), .res(bw_res));
  alu_adder   u_adder   (.sel(in_op[2:0]), .src_a(in_a), .src_b(in_b), .res(add_res));
  alu_compare u_compare (.sel(in_op[2:0]), .src_a(in_a), .src_b(in_b), .res(cmp_res), .cond(br_cond));
  alu_shifter u_shifter (.sel({in_op[7], in_op[4:0]}), .src(in_a), .amt(in_b[AMTW-1:0]), .res(sh_res));

  always_comb begin
    case (in_op[6:5])
      2'b00:   raw_res = bw_res;
      2'b01:   raw_res = add_res;
      2'b10:   raw_res = sh_res;
      default: raw_res = cmp_res;
    endcase
    if (!op_legal || is_branch) res_nxt = '0;
    else if (is_word)           res_nxt = f_sext_lo(raw_res);
    else                        res_nxt = raw_res;
  end

  assign taken_nxt = is_branch && (br_cond ^ in_op[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld   <= 1'b0;
      out_res   <= '0;
      out_taken <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        out_res   <= res_nxt;
        out_taken <= taken_nxt;
      end
    end
  end
endmodule

// File: rtl/alu_checker.sv
module alu_checker
  import alu_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_vld,
  input logic            op_legal,
  input logic            is_branch,
  input logic            is_word,
  input logic            out_vld,
  input logic [XLEN-1:0] out_res,
  input logic            out_taken
);
  assert_vld_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  assert_vld_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(out_res) && $stable(out_taken)));
  assert_branch_zero_res_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && is_branch) |=> (out_res == '0));
  assert_word_sext_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && op_legal && is_word) |=> (out_res[XLEN-1:WLEN] == {WLEN{out_res[WLEN-1]}}));
  assert_no_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !is_branch) |=> !out_taken);
  assert_unlisted_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !op_legal) |=> (out_res == '0));
endmodule

bind int_alu64 alu_checker u_alu_checker (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_legal(op_legal),
  .is_branch(is_branch), .is_word(is_word), .out_vld(out_vld),
  .out_res(out_res), .out_taken(out_taken)
);

// File: tb/test_int_alu64.sv
`timescale 1ns/1ps
module test_int_alu64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [7:0]  in_op = '0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_vld;
  logic [63:0] out_res;
  logic        out_taken;
  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  int_alu64 i_int_alu64 (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .out_vld(out_vld), .out_res(out_res), .out_taken(out_taken));

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] er, input logic et, input string tag);
    @(negedge clk); in_vld = 1'b1; in_op = op; in_a = a; in_b = b;
    @(negedge clk); in_vld = 1'b0;
    chk({tag, " R2 vld"}, {63'd0, out_vld}, 64'd1);
    chk({tag, " res"}, out_res, er);
    chk({tag, " R11 taken"}, {63'd0, out_taken}, {63'd0, et});
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 vld in reset", {63'd0, out_vld}, 64'd0);
    chk("R1 res in reset", out_res, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 vld after release", {63'd0, out_vld}, 64'd0);
    chk("R1 res after release", out_res, 64'd0);
    chk("R1 taken after release", {63'd0, out_taken}, 64'd0);
  endtask

  task automatic t_logic;
    logic [63:0] a = 64'hFF00_FF00_1234_5678, b = 64'h0F0F_0F0F_FFFF_0000;
    apply(8'h00, a, b, 64'h0F00_0F00_1234_0000, 0, "R3 and");
    apply(8'h01, a, b, 64'hF000_F000_0000_5678, 0, "R3 andn");
    apply(8'h02, a, b, 64'hFF0F_FF0F_FFFF_5678, 0, "R3 or");
    apply(8'h03, a, b, 64'hFFF0_FFF0_1234_FFFF, 0, "R3 orn");
    apply(8'h04, a, b, 64'hF00F_F00F_EDCB_5678, 0, "R3 xor");
    apply(8'h05, a, b, 64'h0FF0_0FF0_1234_A987, 0, "R3 xnor");
  endtask

  task automatic t_ext;
    apply(8'h08, 64'h1234_5678_9ABC_DE80, 0, 64'hFFFF_FFFF_FFFF_FF80, 0, "R4 sext byte");
    apply(8'h09, 64'h1234_5678_9ABC_DE80, 0, 64'hFFFF_FFFF_FFFF_DE80, 0, "R4 sext half");
    apply(8'h0A, 64'h1234_5678_9ABC_DE80, 0, 64'h0000_0000_0000_DE80, 0, "R4 zext half");
    apply(8'h0C, 64'h0001_0000_FF00_0010, 0, 64'h00FF_0000_FF00_00FF, 0, "R4 orc byte");
    apply(8'h0D, 64'h0102_0304_0506_0708, 0, 64'h0807_0605_0403_0201, 0, "R4 rev bytes");
  endtask

  task automatic t_add;
    logic [63:0] a = 64'hFFFF_FFFF_0000_0010, b = 64'h100;
    apply(8'h20, a, b, 64'h110, 0, "R5 add zext");
    apply(8'h21, a, b, 64'hFFFF_FFFF_0000_0110, 0, "R5 add");
    apply(8'h22, a, b, 64'h120, 0, "R5 sh1 zext");
    apply(8'h25, a, b, 64'hFFFF_FFFC_0000_0140, 0, "R5 sh2");
    apply(8'h26, a, b, 64'h180, 0, "R5 sh3 zext");
    apply(8'h27, a, b, 64'hFFFF_FFF8_0000_0180, 0, "R5 sh3");
  endtask

  task automatic t_shift;
    logic [63:0] a = 64'h8000_0000_0000_0001;
    apply(8'h41, a, 64'hFFC4, 64'h10, 0, "R6 sll masked amount");
    apply(8'h49, a, 64'd1, 64'h4000_0000_0000_0000, 0, "R6 srl");
    apply(8'h4C, a, 64'd1, 64'hC000_0000_0000_0000, 0, "R6 sra");
    apply(8'h50, a, 64'd1, 64'h3, 0, "R6 rol");
    apply(8'h58, a, 64'd4, 64'h1800_0000_0000_0000, 0, "R6 ror");
    apply(8'h58, a, 64'd0, a, 0, "R6 ror by zero");
    apply(8'h40, 64'hFFFF_FFFF_8000_0001, 64'd4, 64'h0000_0008_0000_0010, 0, "R6 sll zext");
  endtask

  task automatic t_bits;
    apply(8'h44, 64'hF0, 64'd4, 64'hE0, 0, "R7 clear");
    apply(8'h45, 64'hF0, 64'h7F, 64'h8000_0000_0000_00F0, 0, "R7 set masked index");
    apply(8'h46, 64'hF0, 64'd0, 64'hF1, 0, "R7 flip");
    apply(8'h4A, 64'hF0, 64'd5, 64'h1, 0, "R7 extract one");
    apply(8'h4A, 64'hF0, 64'd3, 64'h0, 0, "R7 extract zero");
  endtask

  task automatic t_cmp;
    logic [63:0] a = 64'hFFFF_FFFF_FFFF_FFFE, b = 64'd3;
    apply(8'h60, a, b, 64'hFFFF_FFFF_FFFF_FFFB, 0, "R8 sub");
    apply(8'h61, a, b, 64'd0, 0, "R8 sltu");
    apply(8'h62, a, b, 64'd1, 0, "R8 slt");
    apply(8'h64, a, b, a, 0, "R8 maxu");
    apply(8'h65, a, b, b, 0, "R8 minu");
    apply(8'h66, a, b, b, 0, "R8 max");
    apply(8'h67, a, b, a, 0, "R8 min");
  endtask

  task automatic t_branch;
    logic [63:0] a = 64'hFFFF_FFFF_FFFF_FFFE, b = 64'd3;
    apply(8'h10, a, b, 0, 0, "R9 eq diff");
    apply(8'h11, a, b, 0, 1, "R9 ne diff");
    apply(8'h14, a, b, 0, 1, "R9 lt signed");
    apply(8'h15, a, b, 0, 0, "R9 ge signed");
    apply(8'h16, a, b, 0, 0, "R9 lt unsigned");
    apply(8'h17, a, b, 0, 1, "R9 ge unsigned");
    apply(8'h10, 64'd5, 64'd5, 0, 1, "R9 eq same");
    apply(8'h15, 64'd5, 64'd5, 0, 1, "R9 ge same");
    apply(8'h16, 64'd5, 64'd5, 0, 0, "R9 ltu same");
  endtask

  task automatic t_word;
    apply(8'hA1, 64'h1234_5678_7FFF_FFFF, 64'd1, 64'hFFFF_FFFF_8000_0000, 0, "R10 addw");
    apply(8'hE0, 64'hAAAA_0000_0000_0000, 64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 0, "R10 subw");
    apply(8'hC0, 64'd1, 64'h3F, 64'hFFFF_FFFF_8000_0000, 0, "R10 sllw 5-bit amount");
    apply(8'hC9, 64'hFFFF_FFFF_8000_0000, 64'd4, 64'h0000_0000_0800_0000, 0, "R10 srlw");
    apply(8'hCC, 64'hFFFF_FFFF_8000_0000, 64'd4, 64'hFFFF_FFFF_F800_0000, 0, "R10 sraw");
    apply(8'hD0, 64'h5555_0000_8000_0001, 64'd1, 64'h3, 0, "R10 rolw");
    apply(8'hD8, 64'h5555_0000_0000_0001, 64'd1, 64'hFFFF_FFFF_8000_0000, 0, "R10 rorw");
  endtask

  task automatic t_unlisted;
    apply(8'h02, 64'h55, 64'hAA, 64'hFF, 0, "R3 or before unlisted");
    apply(8'h06, 64'h55, 64'hAA, 64'h0, 0, "R11 code 06");
    apply(8'h11, 64'd1, 64'd2, 64'h0, 1, "R9 ne before unlisted");
    apply(8'h13, 64'd1, 64'd2, 64'h0, 0, "R11 code 13");
    apply(8'h21, 64'd1, 64'd2, 64'h3, 0, "R5 add before unlisted");
    apply(8'h30, 64'd1, 64'd2, 64'h0, 0, "R11 code 30");
    apply(8'hA0, 64'd1, 64'd2, 64'h0, 0, "R11 code A0");
    apply(8'hFF, 64'd1, 64'd2, 64'h0, 0, "R11 code FF");
  endtask

  task automatic t_timing;
    @(negedge clk); in_vld = 1'b1; in_op = 8'h21; in_a = 64'd10; in_b = 64'd5;
    @(negedge clk); in_op = 8'h60;
    chk("R2 back-to-back first vld", {63'd0, out_vld}, 64'd1);
    chk("R2 back-to-back first res", out_res, 64'd15);
    @(negedge clk); in_vld = 1'b0; in_op = 8'h11; in_a = 64'd7; in_b = 64'd9;
    chk("R2 back-to-back second res", out_res, 64'd5);
    @(negedge clk);
    chk("R2 idle vld low", {63'd0, out_vld}, 64'd0);
    chk("R2 idle res held", out_res, 64'd5);
    chk("R2 idle taken held", {63'd0, out_taken}, 64'd0);
    @(negedge clk);
    chk("R2 second idle res held", out_res, 64'd5);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_logic();
    t_ext();
    t_add();
    t_shift();
    t_bits();
    t_cmp();
    t_branch();
    t_word();
    t_unlisted();
    t_timing();
    done = 1;
    summary();
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog R2 actual=hung expected=complete");
      summary();
    end
  end
endmodule